// File: doc/BRIEF.md
# Program/Erase Verify Sequencer with Block Guard

This block sequences single operations on a nonvolatile array that is split into a small number of blocks. A read asks the sense path for data and returns it as soon as sensing reports completion. A program or an erase alternates between requesting an operation pulse and requesting a verify. This repeats until the verify reports success or until an iteration budget runs out. When the budget is exhausted, the target block is marked failed for good.

Each block carries three status flags: failed, write-inhibited and read-inhibited. The flags of the addressed block are examined before any operation is allowed to touch the array. A refused operation finishes at once with its fail indication set. The boot block locks itself against further writes after its first successful program. Completion of every operation is reported by a one-cycle done pulse together with a fail bit.

Top module: `nvseq_top`

## Requirements
- R1: After reset, busy and done are 0, and blk_failed, blk_winh and blk_rinh equal the INIT_FAIL, INIT_WINH and INIT_RINH parameters (all zero by default).
- R2: A command is taken when cmd_valid is 1 while busy is 0. cmd_op encodes 2'b00 read, 2'b01 program, 2'b10 erase and 2'b11 reserved. A reserved opcode, or any opcode aimed at a block whose failed flag is set, finishes with done=1 and fail=1 and raises neither pulse_req nor sense_req.
- R3: A read raises sense_req. In the cycle after the cycle in which sense_done is 1, done=1, fail=0, and rd_data holds the sense_data that was sampled with sense_done.
- R4: A program or erase raises pulse_req until pulse_ack, then verify_req until verify_ack. A failing verify starts another pulse. The first passing verify ends the operation with done=1 and fail=0, so the number of pulses equals the number of iterations the cell needs.
- R5: If verify has failed max(budget,1) times, the operation ends with done=1 and fail=1 after exactly that many pulses, and the block's failed flag is set. A pass on the last allowed iteration counts as success.
- R6: A failed flag never clears, and every later operation to that block, including a read, is refused as in R2.
- R7: A successful program of block BOOT_BLK (0) sets its write-inhibit flag. A successful erase, or a program of any other block, leaves all flags unchanged.
- R8: A program or erase to a write-inhibited block finishes with done=1 and fail=1, with no pulse and no change to any flag. A read of that block proceeds normally.
- R9: A read of a read-inhibited block finishes with done=1 and fail=1 without raising sense_req. A program of that block proceeds normally.
- R10: done is high for exactly one cycle per accepted command. busy is 1 in the cycle after acceptance, and commands presented while busy is 1 are ignored.
- R11: The budget is sampled when the command is accepted. Later changes to the budget input do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Opcode: 00 read, 01 program, 10 erase, 11 reserved |
| cmd_blk | input | BW | Target block index |
| budget | input | CW | Iteration budget for program/erase (0 behaves as 1) |
| busy | output | 1 | An operation is in progress |
| pulse_req | output | 1 | Operation pulse requested from the cell |
| pulse_ack | input | 1 | Pulse applied |
| verify_req | output | 1 | Verify requested from the cell |
| verify_ack | input | 1 | Verify result valid |
| verify_pass | input | 1 | Verify result, 1 = target reached |
| sense_req | output | 1 | Sense requested for a read |
| sense_done | input | 1 | Sense complete, sense_data valid |
| sense_data | input | DW | Sensed word |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the completed operation, 1 = failed or refused |
| rd_data | output | DW | Word returned by the last read |
| blk_failed | output | NBLK | Failed flag per block |
| blk_winh | output | NBLK | Write-inhibit flag per block |
| blk_rinh | output | NBLK | Read-inhibit flag per block |

## Verification
The bench builds the block with four blocks, 8-bit data and budget, block 2 preset write-inhibited and block 3 preset read-inhibited. This brings both inhibit refusal paths within reach from reset, next to the boot-block lock earned on block 0 and failures earned by exhausting the budget on blocks 1 and 3. With an 8-bit budget the cases can be reached in a few cycles: a budget of 0, a pass on exactly the last allowed iteration, and a budget change or a stray command while an operation is running.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHECK  = 3'd1,
    ST_SENSE  = 3'd2,
    ST_PULSE  = 3'd3,
    ST_VERIFY = 3'd4
  } state_e;

endpackage

// File: rtl/nvseq_flags.sv
module nvseq_flags #(
  parameter int NBLK = 4,
  parameter int BW = 2,
  parameter logic [NBLK-1:0] INIT_FAIL = '0,
  parameter logic [NBLK-1:0] INIT_WINH = '0,
  parameter logic [NBLK-1:0] INIT_RINH = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BW-1:0]   sel_blk,
  input  logic            set_fail,
  input  logic            set_winh,
  output logic            sel_fail,
  output logic            sel_winh,
  output logic            sel_rinh,
  output logic [NBLK-1:0] fail_vec,
  output logic [NBLK-1:0] winh_vec,
  output logic [NBLK-1:0] rinh_vec
);

  logic [NBLK-1:0] fail_q;
  logic [NBLK-1:0] winh_q;
  logic [NBLK-1:0] rinh_q;

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    logic hit;
    assign hit = (sel_blk == BW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        fail_q[i] <= INIT_FAIL[i];
        winh_q[i] <= INIT_WINH[i];
        rinh_q[i] <= INIT_RINH[i];
      end else begin
        if (set_fail && hit) fail_q[i] <= 1'b1;
        if (set_winh && hit) winh_q[i] <= 1'b1;
      end
    end
  end

  assign sel_fail = fail_q[sel_blk];
  assign sel_winh = winh_q[sel_blk];
  assign sel_rinh = rinh_q[sel_blk];
  assign fail_vec = fail_q;
  assign winh_vec = winh_q;
  assign rinh_vec = rinh_q;

  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((fail_q & $past(fail_q)) == $past(fail_q)));

  // R7
  winh_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((winh_q & $past(winh_q)) == $past(winh_q)));

endmodule

// File: rtl/nvseq_iter.sv
module nvseq_iter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] budget,
  input  logic          step,
  output logic          last_try
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic [CW:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + (CW+1)'(1);
  assign last_try = (cnt_next >= {1'b0, lim_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= CW'(1);
    end else if (load) begin
      cnt_q <= '0;
      lim_q <= (budget == '0) ? CW'(1) : budget;
    end else if (step && !last_try) begin
      cnt_q <= cnt_next[CW-1:0];
    end
  end

  // R5
  budget_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q < lim_q));

endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
#(
  parameter int BW = 2,
  parameter int DW = 8,
  parameter int BOOT_BLK = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [BW-1:0] cmd_blk,
  output logic          busy,
  output logic [BW-1:0] cur_blk,
  output logic          iter_load,
  output logic          iter_step,
  input  logic          iter_last,
  input  logic          blk_fail,
  input  logic          blk_winh,
  input  logic          blk_rinh,
  output logic          set_fail,
  output logic          set_winh,
  output logic          pulse_req,
  input  logic          pulse_ack,
  output logic          verify_req,
  input  logic          verify_ack,
  input  logic          verify_pass,
  output logic          sense_req,
  input  logic          sense_done,
  input  logic [DW-1:0] sense_data,
  output logic          done,
  output logic          fail,
  output logic [DW-1:0] rd_data
);

  state_e        state_q, state_d;
  op_e           op_q;
  logic [BW-1:0] blk_q;
  logic          refuse;
  logic          is_write;
  logic          finish_ok;
  logic          finish_bad;

  assign is_write = (op_q == OP_PROG) || (op_q == OP_ERASE);
  assign refuse   = blk_fail || (op_q == OP_RSVD) ||
                    (is_write && blk_winh) ||
                    ((op_q == OP_READ) && blk_rinh);

  always_comb begin
    state_d    = state_q;
    iter_load  = 1'b0;
    iter_step  = 1'b0;
    set_fail   = 1'b0;
    set_winh   = 1'b0;
    finish_ok  = 1'b0;
    finish_bad = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          iter_load = 1'b1;
          state_d   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (refuse) begin
          finish_bad = 1'b1;
          state_d    = ST_IDLE;
        end else if (op_q == OP_READ) begin
          state_d = ST_SENSE;
        end else begin
          state_d = ST_PULSE;
        end
      end
      ST_SENSE: begin
        if (sense_done) begin
          finish_ok = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      ST_PULSE: begin
        if (pulse_ack) state_d = ST_VERIFY;
      end
      ST_VERIFY: begin
        if (verify_ack) begin
          if (verify_pass) begin
            finish_ok = 1'b1;
            set_winh  = (op_q == OP_PROG) && (blk_q == BW'(BOOT_BLK));
            state_d   = ST_IDLE;
          end else if (iter_last) begin
            finish_bad = 1'b1;
            set_fail   = 1'b1;
            state_d    = ST_IDLE;
          end else begin
            iter_step = 1'b1;
            state_d   = ST_PULSE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_READ;
      blk_q   <= '0;
      done    <= 1'b0;
      fail    <= 1'b0;
      rd_data <= '0;
    end else begin
      state_q <= state_d;
      done    <= finish_ok || finish_bad;
      if (finish_ok || finish_bad) fail <= finish_bad;
      if ((state_q == ST_SENSE) && sense_done) rd_data <= sense_data;
      if ((state_q == ST_IDLE) && cmd_valid) begin
        op_q  <= op_e'(cmd_op);
        blk_q <= cmd_blk;
      end
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign cur_blk    = blk_q;
  assign pulse_req  = (state_q == ST_PULSE);
  assign verify_req = (state_q == ST_VERIFY);
  assign sense_req  = (state_q == ST_SENSE);

  // R10
  done_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  no_access_failed_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_req || sense_req) |-> !blk_fail);

  // R3
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SENSE) && sense_done) |=> (done && !fail));

  // R7
  boot_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !fail && (op_q == OP_PROG) && (blk_q == BW'(BOOT_BLK))) |-> blk_winh);

  // R8
  winh_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_CHECK) && is_write && blk_winh) |=> (done && fail && !pulse_req));

endmodule

// File: rtl/nvseq_top.sv
module nvseq_top #(
  parameter int NBLK = 4,
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int BOOT_BLK = 0,
  parameter logic [NBLK-1:0] INIT_FAIL = '0,
  parameter logic [NBLK-1:0] INIT_WINH = '0,
  parameter logic [NBLK-1:0] INIT_RINH = '0,
  localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [BW-1:0]   cmd_blk,
  input  logic [CW-1:0]   budget,
  output logic            busy,
  output logic            pulse_req,
  input  logic            pulse_ack,
  output logic            verify_req,
  input  logic            verify_ack,
  input  logic            verify_pass,
  output logic            sense_req,
  input  logic            sense_done,
  input  logic [DW-1:0]   sense_data,
  output logic            done,
  output logic            fail,
  output logic [DW-1:0]   rd_data,
  output logic [NBLK-1:0] blk_failed,
  output logic [NBLK-1:0] blk_winh,
  output logic [NBLK-1:0] blk_rinh
);

  logic [BW-1:0] cur_blk;
  logic iter_load, iter_step, iter_last;
  logic sel_fail, sel_winh, sel_rinh;
  logic set_fail, set_winh;

  nvseq_flags #(
    .NBLK(NBLK), .BW(BW),
    .INIT_FAIL(INIT_FAIL), .INIT_WINH(INIT_WINH), .INIT_RINH(INIT_RINH)
  ) flags_i (
    .clk(clk), .rst(rst), .sel_blk(cur_blk),
    .set_fail(set_fail), .set_winh(set_winh),
    .sel_fail(sel_fail), .sel_winh(sel_winh), .sel_rinh(sel_rinh),
    .fail_vec(blk_failed), .winh_vec(blk_winh), .rinh_vec(blk_rinh)
  );

  nvseq_iter #(.CW(CW)) iter_i (
    .clk(clk), .rst(rst), .load(iter_load), .budget(budget),
    .step(iter_step), .last_try(iter_last)
  );

  nvseq_ctrl #(.BW(BW), .DW(DW), .BOOT_BLK(BOOT_BLK)) ctrl_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .busy(busy), .cur_blk(cur_blk),
    .iter_load(iter_load), .iter_step(iter_step), .iter_last(iter_last),
    .blk_fail(sel_fail), .blk_winh(sel_winh), .blk_rinh(sel_rinh),
    .set_fail(set_fail), .set_winh(set_winh),
    .pulse_req(pulse_req), .pulse_ack(pulse_ack),
    .verify_req(verify_req), .verify_ack(verify_ack), .verify_pass(verify_pass),
    .sense_req(sense_req), .sense_done(sense_done), .sense_data(sense_data),
    .done(done), .fail(fail), .rd_data(rd_data)
  );

endmodule

// File: tb/nvseq_top_tb_top.sv
module nvseq_top_tb_top;

  localparam int NBLK = 4;
  localparam logic [3:0] P_WINH = 4'b0100;
  localparam logic [3:0] P_RINH = 4'b1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [1:0] cmd_blk = 2'b00;
  logic [7:0] budget = 8'd0;
  logic busy, pulse_req, verify_req, sense_req, done, fail;
  logic pulse_ack = 1'b0, verify_ack = 1'b0, verify_pass = 1'b0, sense_done = 1'b0;
  logic [7:0] sense_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] blk_failed, blk_winh, blk_rinh;

  always #5 clk = ~clk;

  nvseq_top #(.NBLK(NBLK), .DW(8), .CW(8), .BOOT_BLK(0),
              .INIT_FAIL(4'b0000), .INIT_WINH(P_WINH), .INIT_RINH(P_RINH)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .budget(budget), .busy(busy), .pulse_req(pulse_req), .pulse_ack(pulse_ack),
    .verify_req(verify_req), .verify_ack(verify_ack), .verify_pass(verify_pass),
    .sense_req(sense_req), .sense_done(sense_done), .sense_data(sense_data),
    .done(done), .fail(fail), .rd_data(rd_data),
    .blk_failed(blk_failed), .blk_winh(blk_winh), .blk_rinh(blk_rinh)
  );

  // cell model controls, written only by the main process
  int need_p = 0;
  int pbase = 0;
  int sdelay = 1;
  logic [7:0] sval = 8'h00;

  // cell model state, written only by the responder
  int pulse_cnt = 0;
  int sense_cnt = 0;
  int cyc = 0;
  int sdone_cyc = 0;
  int done_cyc = 0;
  int swait = 0;

  initial begin
    forever begin
      @(negedge clk);
      cyc = cyc + 1;
      if (done) done_cyc = cyc;
      if (pulse_req && !pulse_ack) begin
        pulse_ack = 1'b1;
        pulse_cnt = pulse_cnt + 1;
      end else begin
        pulse_ack = 1'b0;
      end
      if (verify_req && !verify_ack) begin
        verify_ack  = 1'b1;
        verify_pass = ((pulse_cnt - pbase) >= need_p);
      end else begin
        verify_ack  = 1'b0;
        verify_pass = 1'b0;
      end
      if (sense_req && !sense_done) begin
        swait = swait + 1;
        if (swait >= sdelay) begin
          sense_done = 1'b1;
          sense_data = sval;
          sense_cnt  = sense_cnt + 1;
          sdone_cyc  = cyc;
          swait      = 0;
        end
      end else begin
        sense_done = 1'b0;
        swait      = 0;
      end
    end
  end

  int checks = 0;
  int failures = 0;
  logic wd_hit = 1'b0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic r_fail;
  logic [7:0] r_data;
  int r_pulses, r_senses, r_cycles;

  task automatic issue(input logic [1:0] op, input logic [1:0] blk, input logic [7:0] bud,
                       input int need);
    @(negedge clk);
    pbase     = pulse_cnt;
    need_p    = need;
    cmd_op    = op;
    cmd_blk   = blk;
    budget    = bud;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
  endtask

  task automatic finish_op(input int s0);
    int n;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n = n + 1;
    end
    chk(done == 1'b1, "R10 done reached", int'(done), 1);
    r_fail   = fail;
    r_data   = rd_data;
    r_pulses = pulse_cnt - pbase;
    r_senses = sense_cnt - s0;
    r_cycles = n;
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [1:0] blk, input logic [7:0] bud,
                        input int need);
    int s0;
    s0 = sense_cnt;
    issue(op, blk, bud, need);
    finish_op(s0);
  endtask

  typedef struct packed {
    logic [1:0] op;
    logic [1:0] blk;
    logic [7:0] bud;
    logic [7:0] need;
    logic       efail;
    logic [7:0] epul;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd1, 8'd5, 8'd3, 1'b0, 8'd3},   // R4 program passes after 3
    '{2'd1, 2'd1, 8'd3, 8'd3, 1'b0, 8'd3},   // R5 pass on last allowed try
    '{2'd2, 2'd1, 8'd4, 8'd1, 1'b0, 8'd1},   // R4 erase passes first try
    '{2'd1, 2'd0, 8'd3, 8'd2, 1'b0, 8'd2},   // R7 boot program locks block 0
    '{2'd1, 2'd0, 8'd3, 8'd1, 1'b1, 8'd0},   // R7 locked boot block refuses
    '{2'd2, 2'd0, 8'd3, 8'd1, 1'b1, 8'd0},   // R8 erase of locked block
    '{2'd1, 2'd2, 8'd3, 8'd1, 1'b1, 8'd0},   // R8 preset write inhibit
    '{2'd2, 2'd1, 8'd2, 8'd9, 1'b1, 8'd2},   // R5 budget exhausted
    '{2'd1, 2'd1, 8'd9, 8'd1, 1'b1, 8'd0},   // R6 failed block refuses
    '{2'd2, 2'd3, 8'd0, 8'd5, 1'b1, 8'd1},   // R5 budget 0 acts as 1
    '{2'd1, 2'd3, 8'd5, 8'd1, 1'b1, 8'd0}    // R6 second failed block
  };

  logic [3:0] ex_fail, ex_winh;

  task automatic run_all();
    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'({busy, done}), 0);
    chk(blk_failed == 4'b0000, "R1 failed flags", int'(blk_failed), 0);
    chk(blk_winh == P_WINH, "R1 winh flags", int'(blk_winh), int'(P_WINH));
    chk(blk_rinh == P_RINH, "R1 rinh flags", int'(blk_rinh), int'(P_RINH));
    ex_fail = 4'b0000;
    ex_winh = P_WINH;

    // R3 read with sense delay, data in cycle after sense_done
    sdelay = 3; sval = 8'hA5;
    run_op(2'b00, 2'd0, 8'd1, 0);
    chk(r_fail == 1'b0, "R3 read ok", int'(r_fail), 0);
    chk(r_data == 8'hA5, "R3 read data", int'(r_data), 8'hA5);
    chk(done_cyc == sdone_cyc + 1, "R3 read latency", done_cyc - sdone_cyc, 1);
    chk(r_senses == 1, "R3 one sense", r_senses, 1);

    // R8 read of write-inhibited block allowed
    sdelay = 1; sval = 8'h3C;
    run_op(2'b00, 2'd2, 8'd1, 0);
    chk(r_fail == 1'b0 && r_data == 8'h3C, "R8 read winh block", int'(r_data), 8'h3C);
    chk(done_cyc == sdone_cyc + 1, "R3 read latency short", done_cyc - sdone_cyc, 1);

    // R9 read-inhibited block
    run_op(2'b00, 2'd3, 8'd1, 0);
    chk(r_fail == 1'b1, "R9 read refused", int'(r_fail), 1);
    chk(r_senses == 0, "R9 no sense", r_senses, 0);
    chk(r_data == 8'h3C, "R9 rd_data kept", int'(r_data), 8'h3C);
    run_op(2'b01, 2'd3, 8'd4, 2);
    chk(r_fail == 1'b0 && r_pulses == 2, "R9 program of rinh block", r_pulses, 2);

    // R2 reserved opcode
    run_op(2'b11, 2'd1, 8'd4, 1);
    chk(r_fail == 1'b1 && r_pulses == 0 && r_senses == 0, "R2 reserved op",
        r_pulses + r_senses, 0);
    chk(blk_failed == ex_fail && blk_winh == ex_winh, "R2 flags unchanged",
        int'({blk_failed, blk_winh}), int'({ex_fail, ex_winh}));

    // R10 R11 budget change and stray command while busy
    begin
      int s0;
      s0 = sense_cnt;
      issue(2'b01, 2'd1, 8'd5, 3);
      budget = 8'd1;
      @(negedge clk);
      cmd_op = 2'b10; cmd_blk = 2'd1; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      finish_op(s0);
      chk(r_fail == 1'b0 && r_pulses == 3, "R11 budget latched", r_pulses, 3);
      begin
        int extra;
        extra = 0;
        for (int k = 0; k < 5; k++) begin
          @(negedge clk);
          if (done || busy) extra = extra + 1;
        end
        chk(extra == 0, "R10 busy command ignored", extra, 0);
      end
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      run_op(VECS[v].op, VECS[v].blk, VECS[v].bud, int'(VECS[v].need));
      chk(r_fail == VECS[v].efail, $sformatf("R4 R5 vec %0d fail bit", v),
          int'(r_fail), int'(VECS[v].efail));
      chk(r_pulses == int'(VECS[v].epul), $sformatf("R4 R5 vec %0d pulses", v),
          r_pulses, int'(VECS[v].epul));
      chk(r_senses == 0, $sformatf("R2 vec %0d no sense", v), r_senses, 0);
      if (VECS[v].efail && VECS[v].epul != 0) ex_fail[VECS[v].blk] = 1'b1;
      if (!VECS[v].efail && VECS[v].op == 2'b01 && VECS[v].blk == 2'd0) ex_winh[0] = 1'b1;
      chk(blk_failed == ex_fail, $sformatf("R5 R6 vec %0d failed flags", v),
          int'(blk_failed), int'(ex_fail));
      chk(blk_winh == ex_winh, $sformatf("R7 R8 vec %0d winh flags", v),
          int'(blk_winh), int'(ex_winh));
      chk(blk_rinh == P_RINH, $sformatf("R9 vec %0d rinh flags", v),
          int'(blk_rinh), int'(P_RINH));
    end

    // R6 read of failed block
    run_op(2'b00, 2'd1, 8'd1, 0);
    chk(r_fail == 1'b1 && r_senses == 0, "R6 read of failed block", r_senses, 0);
    chk(blk_failed == 4'b1010 && blk_winh == 4'b0101, "R6 R7 final flags",
        int'({blk_failed, blk_winh}), 8'hA5);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule